// File: doc/BRIEF.md
# Compare-Match Interval Timer with Gated Toggle Output

The block is an up-counting interval timer. A count register advances on each qualified tick and is compared for exact equality against a reference register. When the two are equal, the block does three things. It pulses an interrupt request, it inverts a retained output latch, and it returns the count to zero. The period between matches is therefore reference + 1 qualified ticks.

A separate output-enable flag decides whether the latch value reaches the output pin. A start control restarts the count and clears the latch. Dropping the run-enable freezes both the count and the latch where they are.

The block is fed a single count-enable strobe from an external prescaler or event source. Its host-side controls are simple write strobes with data.

Top module: `match_toggle_timer`

## Requirements
- R1: After reset the reference holds all ones (0xFF for the default 8-bit width), the count is 0, the latch is 0, the output-enable flag reads 0, and pin_o and irq_o are 0.
- R2: The count advances by one only in cycles where tick_i and run_i are both 1. irq_o can be 1 only in such a cycle.
- R3: In a qualified tick cycle where the count equals the reference, irq_o is 1 in that same cycle. On the closing clock edge the latch inverts and the count goes to 0. Successive irq_o pulses are therefore reference + 1 qualified ticks apart.
- R4: A reference of 0 gives irq_o on every qualified tick, and the latch toggles each time. A reference of 0xFF gives 256 qualified ticks per interval.
- R5: pin_o equals the latch value while the output-enable flag is 1. pin_o is 0 while the flag is 0, and the latch still toggles on matches during that time.
- R6: A write with oe_we_i=1 stores oe_wdata_i into the output-enable flag from the next cycle. oe_rdata_o always shows the stored flag.
- R7: start_i=1 clears the count and the latch at the clock edge. It takes priority over a coinciding match: irq_o stays 0 and no toggle happens.
- R8: While run_i=0, ticks are ignored. The count and the latch hold their values, and irq_o stays 0 even when the count equals the reference.
- R9: A reference write with ref_we_i=1 takes effect for the next comparison. If the count already lies above the new value, counting runs through 0xFF and wraps to 0 before the match.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | Count-enable strobe from the prescaler |
| run_i | input | 1 | Run enable; 0 freezes the count and the latch |
| start_i | input | 1 | Restart: clears the count and the latch |
| ref_we_i | input | 1 | Reference register write strobe |
| ref_wdata_i | input | CNT_W | Reference write data |
| oe_we_i | input | 1 | Output-enable flag write strobe |
| oe_wdata_i | input | 1 | Output-enable flag write data |
| oe_rdata_o | output | 1 | Output-enable flag read value |
| pin_o | output | 1 | Latch value gated by the output-enable flag |
| irq_o | output | 1 | One-cycle interrupt request on a match |

## Verification
The count is not visible at the ports, so a wrong count value shows up as a shifted irq_o pulse. That shift appears within one interval, at most 256 ticks. A latch that fails to toggle or fails to clear on start shows at pin_o on the very next cycle, provided the output-enable flag is set. The bench measures the spacing between interrupts for several reference values, including a write that lands below the running count. It also tracks pin_o edge by edge across run-disable and start events.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  typedef struct packed {
    logic clr;   // restart request
    logic adv;   // qualified tick
  } tmr_ctrl_t;
endpackage

// File: rtl/tmr_ref_reg.sv
module tmr_ref_reg #(
  parameter int unsigned W = 8,
  parameter logic [W-1:0] RST_VAL = '1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         we_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] ref_o
);
  logic [W-1:0] ref_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   ref_q <= RST_VAL;
    else if (we_i) ref_q <= wdata_i;
  end

  assign ref_o = ref_q;

  assert_ref_write_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> ref_q == $past(wdata_i));
endmodule

// File: rtl/tmr_count.sv
module tmr_count
  import tmr_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  tmr_ctrl_t    ctrl_i,
  input  logic [W-1:0] ref_i,
  output logic         match_o
);
  logic [W-1:0] cnt_q;
  logic         eq;

  assign eq      = (cnt_q == ref_i);
  assign match_o = ctrl_i.adv & eq;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           cnt_q <= '0;
    else if (ctrl_i.clr)   cnt_q <= '0;
    else if (match_o)      cnt_q <= '0;
    else if (ctrl_i.adv)   cnt_q <= cnt_q + 1'b1;  // wraps at all-ones
  end

  assert_restart_after_match_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    match_o |=> cnt_q == '0);
  assert_hold_when_idle_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ctrl_i.adv && !ctrl_i.clr) |=> $stable(cnt_q));
  assert_clear_on_start_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_i.clr |=> cnt_q == '0);
endmodule

// File: rtl/tmr_out_latch.sv
module tmr_out_latch (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic toggle_i,
  input  logic clr_i,
  input  logic oe_we_i,
  input  logic oe_wdata_i,
  output logic oe_o,
  output logic pin_o
);
  logic lat_q;
  logic oe_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       lat_q <= 1'b0;
    else if (clr_i)    lat_q <= 1'b0;
    else if (toggle_i) lat_q <= ~lat_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       oe_q <= 1'b0;
    else if (oe_we_i)  oe_q <= oe_wdata_i;
  end

  assign oe_o  = oe_q;
  assign pin_o = oe_q & lat_q;

  assert_toggle_on_match_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (toggle_i && !clr_i) |=> lat_q != $past(lat_q));
  assert_start_clears_latch_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> !lat_q);
  assert_latch_retained_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!toggle_i && !clr_i) |=> $stable(lat_q));
  assert_oe_write_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    oe_we_i |=> oe_q == $past(oe_wdata_i));
  assert_pin_gated_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !oe_q |-> !pin_o);
endmodule

// File: rtl/match_toggle_timer.sv
module match_toggle_timer
  import tmr_pkg::*;
#(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             run_i,
  input  logic             start_i,
  input  logic             ref_we_i,
  input  logic [CNT_W-1:0] ref_wdata_i,
  input  logic             oe_we_i,
  input  logic             oe_wdata_i,
  output logic             oe_rdata_o,
  output logic             pin_o,
  output logic             irq_o
);
  localparam logic [CNT_W-1:0] REF_RST = {CNT_W{1'b1}};

  tmr_ctrl_t        ctrl;
  logic [CNT_W-1:0] ref_val;
  logic             match;
  logic             hit;

  assign ctrl.clr = start_i;
  assign ctrl.adv = tick_i & run_i;

  tmr_ref_reg #(.W(CNT_W), .RST_VAL(REF_RST)) i_ref (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (ref_we_i),
    .wdata_i (ref_wdata_i),
    .ref_o   (ref_val)
  );

  tmr_count #(.W(CNT_W)) i_cnt (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .ctrl_i  (ctrl),
    .ref_i   (ref_val),
    .match_o (match)
  );

  // start wins over a coinciding match
  assign hit   = match & ~start_i;
  assign irq_o = hit;

  tmr_out_latch i_lat (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .toggle_i   (hit),
    .clr_i      (start_i),
    .oe_we_i    (oe_we_i),
    .oe_wdata_i (oe_wdata_i),
    .oe_o       (oe_rdata_o),
    .pin_o      (pin_o)
  );

  assert_irq_needs_tick_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (tick_i && run_i));
  assert_no_irq_on_start_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |-> !irq_o);
endmodule

// File: tb/test_match_toggle_timer.sv
module test_match_toggle_timer;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0, run = 1'b0, start = 1'b0;
  logic       ref_we = 1'b0, oe_we = 1'b0, oe_wd = 1'b0;
  logic [7:0] ref_wd = '0;
  logic       oe_rd, pin, irq;

  int compared = 0;
  int mismatched = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;  // 250 MHz

  match_toggle_timer #(.CNT_W(8)) i_match_toggle_timer (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .run_i(run), .start_i(start),
    .ref_we_i(ref_we), .ref_wdata_i(ref_wd), .oe_we_i(oe_we), .oe_wdata_i(oe_wd),
    .oe_rdata_o(oe_rd), .pin_o(pin), .irq_o(irq)
  );

  // {start, run, tick, ref_we, ref_data[8], oe_we, oe_data, exp_irq, exp_pin}
  localparam int NV = 22;
  localparam logic [15:0] VEC [NV] = '{
    16'b0_1_0_1_00000010_1_1_0_0, // load ref 2, oe on (R6)
    16'b0_1_1_0_00000000_0_0_0_0, // cnt0 (R2)
    16'b0_1_1_0_00000000_0_0_0_0, // cnt1
    16'b0_1_1_0_00000000_0_0_1_0, // cnt2 match (R3)
    16'b0_1_0_0_00000000_0_0_0_1, // latch now 1 (R5)
    16'b0_0_1_0_00000000_0_0_0_1, // run off, tick ignored (R8)
    16'b0_1_1_0_00000000_0_0_0_1, // cnt0
    16'b0_1_1_0_00000000_0_0_0_1, // cnt1
    16'b0_0_1_0_00000000_0_0_0_1, // cnt2 but run off: no irq (R8)
    16'b0_1_1_0_00000000_0_0_1_1, // cnt2 match
    16'b0_1_0_0_00000000_1_0_0_0, // latch 0, oe off
    16'b0_1_1_0_00000000_0_0_0_0,
    16'b0_1_1_0_00000000_0_0_0_0,
    16'b0_1_1_0_00000000_0_0_1_0, // match, pin gated (R5)
    16'b0_1_0_0_00000000_1_1_0_0, // oe on next cycle
    16'b0_1_1_0_00000000_0_0_0_1, // latch toggled while gated
    16'b0_1_1_0_00000000_0_0_0_1,
    16'b1_1_1_0_00000000_0_0_0_1, // start with coinciding match (R7)
    16'b0_1_0_0_00000000_0_0_0_0, // latch cleared
    16'b0_1_1_0_00000000_0_0_0_0, // cnt0 after start
    16'b0_1_1_0_00000000_0_0_0_0,
    16'b0_1_1_0_00000000_0_0_1_0  // cnt2 match
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic drive(input logic s, input logic r, input logic t, input logic rw,
                       input logic [7:0] rd, input logic ow, input logic od);
    @(negedge clk);
    start = s; run = r; tick = t; ref_we = rw; ref_wd = rd; oe_we = ow; oe_wd = od;
    #1;
  endtask

  task automatic idle();
    drive(1'b0, 1'b1, 1'b0, 1'b0, 8'h00, 1'b0, 1'b0);
  endtask

  // qualified ticks up to and including the one that raises irq
  task automatic ticks_to_irq(output int n);
    n = 0;
    for (int k = 0; k < 600; k++) begin
      drive(1'b0, 1'b1, 1'b1, 1'b0, 8'h00, 1'b0, 1'b0);
      n++;
      if (irq) break;
    end
    idle();
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    start = 0; run = 0; tick = 0; ref_we = 0; oe_we = 0; oe_wd = 0; ref_wd = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    finish_run();
  end

  initial begin
    int n;
    logic p;
    do_reset();
    #1;
    check("R1 oe after reset", oe_rd, 0);
    check("R1 pin after reset", pin, 0);
    check("R1 irq after reset", irq, 0);

    for (int i = 0; i < NV; i++) begin
      logic [15:0] v;
      v = VEC[i];
      drive(v[15], v[14], v[13], v[12], v[11:4], v[3], v[2]);
      check($sformatf("R2/R3/R5/R7/R8 vec%0d irq", i), irq, v[1]);
      check($sformatf("R2/R3/R5/R7/R8 vec%0d pin", i), pin, v[0]);
    end

    // R1/R4: reset reference gives 256 ticks per interval
    do_reset();
    ticks_to_irq(n);
    check("R1 R4 first interval ref 0xFF", n, 256);
    ticks_to_irq(n);
    check("R4 second interval ref 0xFF", n, 256);

    // R6: flag readback
    drive(1'b0, 1'b1, 1'b0, 1'b0, 8'h00, 1'b1, 1'b1);
    idle();
    check("R6 oe reads 1", oe_rd, 1);
    drive(1'b0, 1'b1, 1'b0, 1'b0, 8'h00, 1'b1, 1'b0);
    idle();
    check("R6 oe reads 0", oe_rd, 0);
    drive(1'b0, 1'b1, 1'b0, 1'b0, 8'h00, 1'b1, 1'b1);

    // R4: ref 0 toggles every qualified tick
    drive(1'b1, 1'b1, 1'b0, 1'b1, 8'h00, 1'b0, 1'b0);
    idle();
    p = pin;
    check("R7 pin after start", p, 0);
    for (int k = 0; k < 4; k++) begin
      drive(1'b0, 1'b1, 1'b1, 1'b0, 8'h00, 1'b0, 1'b0);
      check("R4 ref0 irq each tick", irq, 1);
      check("R4 ref0 pin toggles", pin, 32'(p ^ k[0]));
    end
    idle();

    // R9: new ref below running count wraps through 0xFF
    drive(1'b1, 1'b1, 1'b0, 1'b1, 8'd10, 1'b0, 1'b0);
    for (int k = 0; k < 6; k++) begin
      drive(1'b0, 1'b1, 1'b1, 1'b0, 8'h00, 1'b0, 1'b0);
      check("R9 no early irq", irq, 0);
    end
    drive(1'b0, 1'b1, 1'b0, 1'b1, 8'd3, 1'b0, 1'b0);
    ticks_to_irq(n);
    check("R9 wrap before match", n, 254);
    ticks_to_irq(n);
    check("R3 interval ref 3", n, 4);

    // R9: new ref above running count matches in the same pass
    drive(1'b1, 1'b1, 1'b0, 1'b1, 8'd10, 1'b0, 1'b0);
    drive(1'b0, 1'b1, 1'b1, 1'b0, 8'h00, 1'b0, 1'b0);
    drive(1'b0, 1'b1, 1'b1, 1'b0, 8'h00, 1'b0, 1'b0);
    drive(1'b0, 1'b1, 1'b0, 1'b1, 8'd5, 1'b0, 1'b0);
    ticks_to_irq(n);
    check("R9 new ref above count", n, 4);

    // R1: reset mid-run restores defaults
    do_reset();
    #1;
    check("R1 oe after second reset", oe_rd, 0);
    check("R1 pin after second reset", pin, 0);
    finish_run();
  end
endmodule